// File: doc/BRIEF.md
# Programmable-Increment System Time Counter

This block keeps a 64-bit time-of-day count that hardware timestamping logic can sample. The count does not step by one on every clock. A control word sets a period of N input clock ticks and an increment value. Each time N ticks have passed, the increment is added to the count. Software scales the increment so that the low bits of the count hold fractional nanoseconds. Small changes to the increment then trim the effective frequency.

Software reaches the block through a small register bus that has three 32-bit locations. Word 0 is the low half of the time and word 1 is the high half. Word 2 is the increment control word. Reading the low half freezes the high half in a shadow register, so a later read of the high half gives a consistent 64-bit value. A write to the low half is held until the high half is written, and then both halves load at once. A new control word is taken up only at a period boundary.

Top module: `systime_counter`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears the count, the held low word, the shadow, the tick divider, the control word and the read data. After that edge `time_now` and `bus_rdata` are zero.
- R2: In the control word (address 2), bits 31:24 set the period P in clock ticks and bits 23:0 set the increment I. Once a control word is active with P > 0, `time_now` rises by I exactly once every P clocks.
- R3: The control word with P = 3 and I = 125<<17 (0x03FA0000) adds 0xFA0000 every third clock.
- R4: The control word with P = 1 and I = 40<<18 (0x01A00000) adds 0xA00000 on every clock.
- R5: The count wraps modulo 2^64. Adding I to a value near 2^64 leaves the low 64 bits of the sum.
- R6: A read of address 0 returns the low half and, in the same cycle, copies the high half into a shadow. A later read of address 1 returns the shadow, even if the count has moved since.
- R7: A write to address 0 does not change the count. A later write to address 1 loads {high data, held low data} in one cycle and restarts the tick divider at zero. A step that falls on the load cycle is dropped.
- R8: An active period of zero holds the count still.
- R9: A control word written while a period is running takes effect only at the next boundary. That boundary still adds the old increment, and the new period counts from there. When the counter is stopped, a new word takes effect on the next clock.
- R10: Read data appears on `bus_rdata` one clock after the read request and holds until the next read. Address 2 reads back the last control word written. Address 3 reads zero and ignores writes.
- R11: A synchronous reset during a run clears the count and the shadow, and the counter stays at zero until a new control word is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the tick source |
| rst | input | 1 | Synchronous reset, active high |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Word select: 0 time low, 1 time high, 2 control, 3 unused |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| time_now | output | 64 | Current count for timestamp consumers |

## Verification
A divider that is one tick off, or a control word taken up in the middle of a period, shifts the step cycle on `time_now`. The bench compares `time_now` on every clock, so such a fault shows within one period of the first bad boundary. A stale or missing shadow capture appears in `bus_rdata` on the cycle after the high-half read. A low write that leaks into the count shows as a jump in `time_now` on the very next clock.

// File: rtl/systime_pkg.sv
package systime_pkg;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned PER_W  = 8;
    localparam int unsigned INC_W  = WORD_W - PER_W;

    typedef enum logic [1:0] {
        SEL_TIME_LO  = 2'd0,
        SEL_TIME_HI  = 2'd1,
        SEL_STEP_CFG = 2'd2,
        SEL_SPARE    = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [PER_W-1:0] period;
        logic [INC_W-1:0] incr;
    } step_cfg_t;

    function automatic step_cfg_t to_cfg(input logic [WORD_W-1:0] w);
        return step_cfg_t'(w);
    endfunction

    function automatic logic [WORD_W-1:0] from_cfg(input step_cfg_t c);
        return WORD_W'(c);
    endfunction

endpackage

// File: rtl/tick_gen.sv
module tick_gen
    import systime_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  step_cfg_t        pend_cfg,
    input  logic             restart,
    output logic             step,
    output step_cfg_t        act_cfg,
    output logic [PER_W-1:0] div_q
);
    logic stopped;
    logic boundary;

    assign stopped  = (act_cfg.period == '0);
    assign boundary = !stopped && (div_q == act_cfg.period - 1'b1);
    assign step     = boundary;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_cfg <= '0;
            div_q   <= '0;
        end else if (stopped || boundary) begin
            act_cfg <= pend_cfg;
            div_q   <= '0;
        end else if (restart) begin
            div_q   <= '0;
        end else begin
            div_q   <= div_q + 1'b1;
        end
    end
endmodule

// File: rtl/time_accum.sv
module time_accum
    import systime_pkg::*;
#(
    parameter int unsigned HALF_W = WORD_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_lo,
    input  logic                wr_hi,
    input  logic [HALF_W-1:0]   wdata,
    input  logic                step,
    input  logic [INC_W-1:0]    incr,
    output logic [2*HALF_W-1:0] time_q,
    output logic [HALF_W-1:0]   lo_hold
);
    localparam int unsigned CNT_W = 2 * HALF_W;

    logic [CNT_W-1:0] incr_ext;
    assign incr_ext = {{(CNT_W-INC_W){1'b0}}, incr};

    always_ff @(posedge clk) begin
        if (rst) begin
            time_q  <= '0;
            lo_hold <= '0;
        end else begin
            if (wr_lo)
                lo_hold <= wdata;
            if (wr_hi)
                time_q <= {wdata, lo_hold};
            else if (step)
                time_q <= time_q + incr_ext;
        end
    end
endmodule

// File: rtl/reg_readback.sv
module reg_readback
    import systime_pkg::*;
#(
    parameter int unsigned HALF_W = WORD_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                rd_en,
    input  reg_sel_e            rd_sel,
    input  logic [2*HALF_W-1:0] time_q,
    input  logic [HALF_W-1:0]   cfg_word,
    output logic [HALF_W-1:0]   rdata,
    output logic [HALF_W-1:0]   shadow
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rdata  <= '0;
            shadow <= '0;
        end else if (rd_en) begin
            unique case (rd_sel)
                SEL_TIME_LO: begin
                    rdata  <= time_q[HALF_W-1:0];
                    shadow <= time_q[2*HALF_W-1:HALF_W];
                end
                SEL_TIME_HI:  rdata <= shadow;
                SEL_STEP_CFG: rdata <= cfg_word;
                default:      rdata <= '0;
            endcase
        end
    end
endmodule

// File: rtl/systime_counter.sv
module systime_counter
    import systime_pkg::*;
#(
    parameter int unsigned HALF_W = WORD_W,
    localparam int unsigned CNT_W = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [1:0]        bus_addr,
    input  logic [HALF_W-1:0] bus_wdata,
    output logic [HALF_W-1:0] bus_rdata,
    output logic [CNT_W-1:0]  time_now
);
    reg_sel_e         sel;
    logic             wr_lo, wr_hi, wr_cfg, rd_any;
    step_cfg_t        cfg_q;
    step_cfg_t        act_cfg;
    logic             tick_step;
    logic [PER_W-1:0] div_cnt;
    logic [HALF_W-1:0] lo_hold;
    logic [HALF_W-1:0] shadow_hi;

    assign sel    = reg_sel_e'(bus_addr);
    assign wr_lo  = bus_en && bus_we && (sel == SEL_TIME_LO);
    assign wr_hi  = bus_en && bus_we && (sel == SEL_TIME_HI);
    assign wr_cfg = bus_en && bus_we && (sel == SEL_STEP_CFG);
    assign rd_any = bus_en && !bus_we;

    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= '0;
        else if (wr_cfg)
            cfg_q <= to_cfg(bus_wdata);
    end

    tick_gen u_tick (
        .clk      (clk),
        .rst      (rst),
        .pend_cfg (cfg_q),
        .restart  (wr_hi),
        .step     (tick_step),
        .act_cfg  (act_cfg),
        .div_q    (div_cnt)
    );

    time_accum #(.HALF_W(HALF_W)) u_accum (
        .clk     (clk),
        .rst     (rst),
        .wr_lo   (wr_lo),
        .wr_hi   (wr_hi),
        .wdata   (bus_wdata),
        .step    (tick_step),
        .incr    (act_cfg.incr),
        .time_q  (time_now),
        .lo_hold (lo_hold)
    );

    reg_readback #(.HALF_W(HALF_W)) u_rd (
        .clk      (clk),
        .rst      (rst),
        .rd_en    (rd_any),
        .rd_sel   (sel),
        .time_q   (time_now),
        .cfg_word (from_cfg(cfg_q)),
        .rdata    (bus_rdata),
        .shadow   (shadow_hi)
    );
endmodule

// File: rtl/systime_checker.sv
module systime_checker
    import systime_pkg::*;
#(
    parameter int unsigned HALF_W = WORD_W,
    localparam int unsigned CNT_W = 2 * HALF_W
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_en,
    input logic              bus_we,
    input logic [1:0]        bus_addr,
    input logic [HALF_W-1:0] bus_wdata,
    input logic [HALF_W-1:0] bus_rdata,
    input logic [CNT_W-1:0]  time_now,
    input logic              tick_step,
    input logic [INC_W-1:0]  act_incr,
    input logic [PER_W-1:0]  act_period,
    input logic [PER_W-1:0]  div_cnt,
    input logic [HALF_W-1:0] lo_hold,
    input logic [HALF_W-1:0] shadow_hi
);
    logic hi_wr;
    logic hi_rd;
    assign hi_wr = bus_en && bus_we && (bus_addr == 2'd1);
    assign hi_rd = bus_en && !bus_we && (bus_addr == 2'd1);

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (time_now == '0 && bus_rdata == '0));

    a_r2_div_in_range: assert property (@(posedge clk) disable iff (rst)
        (act_period != '0) |-> (div_cnt < act_period));

    a_r5_step_adds: assert property (@(posedge clk) disable iff (rst)
        (tick_step && !hi_wr) |=>
        (time_now == $past(time_now) + {{(CNT_W-INC_W){1'b0}}, $past(act_incr)}));

    a_r8_no_step_holds: assert property (@(posedge clk) disable iff (rst)
        (!tick_step && !hi_wr) |=> $stable(time_now));

    a_r7_pair_load: assert property (@(posedge clk) disable iff (rst)
        hi_wr |=> (time_now == {$past(bus_wdata), $past(lo_hold)} && div_cnt == '0));

    a_r6_shadow_read: assert property (@(posedge clk) disable iff (rst)
        hi_rd |=> (bus_rdata == $past(shadow_hi)));
endmodule

bind systime_counter systime_checker #(.HALF_W(HALF_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_en     (bus_en),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .time_now   (time_now),
    .tick_step  (tick_step),
    .act_incr   (act_cfg.incr),
    .act_period (act_cfg.period),
    .div_cnt    (div_cnt),
    .lo_hold    (lo_hold),
    .shadow_hi  (shadow_hi)
);

// File: tb/sim_systime_counter.sv
module sim_systime_counter;
    logic        clk = 1'b0;
    logic        rst;
    logic        bus_en;
    logic        bus_we;
    logic [1:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [63:0] time_now;

    int vectors = 0;
    int fails   = 0;
    bit done    = 1'b0;
    string tag  = "R1";

    logic [63:0] m_cnt;
    logic [31:0] m_lo, m_sh, m_rd, m_ctrl;
    logic [23:0] m_inc;
    int          m_per, m_div;

    always #10 clk = ~clk;

    systime_counter u0 (
        .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .time_now(time_now)
    );

    task automatic cyc(input bit r, input bit en, input bit we,
                       input logic [1:0] a, input logic [31:0] d);
        logic [63:0] n_cnt;
        logic [31:0] n_lo, n_sh, n_rd, n_ctrl;
        logic [23:0] n_inc;
        int n_per, n_div;
        bit bnd, load;
        rst = r; bus_en = en; bus_we = we; bus_addr = a; bus_wdata = d;
        if (r) begin
            n_cnt = '0; n_lo = '0; n_sh = '0; n_rd = '0; n_ctrl = '0;
            n_inc = '0; n_per = 0; n_div = 0;
        end else begin
            n_cnt = m_cnt; n_lo = m_lo; n_sh = m_sh; n_rd = m_rd;
            n_ctrl = m_ctrl; n_inc = m_inc; n_per = m_per; n_div = m_div;
            load = en && we && a == 2'd1;
            if (en && !we) begin
                case (a)
                    2'd0: begin n_rd = m_cnt[31:0]; n_sh = m_cnt[63:32]; end
                    2'd1: n_rd = m_sh;
                    2'd2: n_rd = m_ctrl;
                    default: n_rd = '0;
                endcase
            end
            if (en && we && a == 2'd0) n_lo = d;
            if (en && we && a == 2'd2) n_ctrl = d;
            bnd = (m_per != 0) && (m_div == m_per - 1);
            if (m_per == 0 || bnd) begin
                n_per = int'(m_ctrl[31:24]); n_inc = m_ctrl[23:0]; n_div = 0;
            end else if (load) n_div = 0;
            else n_div = m_div + 1;
            if (load) n_cnt = {d, m_lo};
            else if (bnd) n_cnt = m_cnt + 64'(m_inc);
        end
        @(posedge clk);
        #2;
        m_cnt = n_cnt; m_lo = n_lo; m_sh = n_sh; m_rd = n_rd;
        m_ctrl = n_ctrl; m_inc = n_inc; m_per = n_per; m_div = n_div;
        vectors++;
        if (time_now !== m_cnt) begin
            fails++;
            $display("FAIL %s time_now actual=%h expected=%h", tag, time_now, m_cnt);
        end
        if (bus_rdata !== m_rd) begin
            fails++;
            $display("FAIL %s bus_rdata actual=%h expected=%h", tag, bus_rdata, m_rd);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 2'd0, '0);
    endtask
    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        cyc(0, 1, 1, a, d);
    endtask
    task automatic rd(input logic [1:0] a);
        cyc(0, 1, 0, a, '0);
    endtask

    initial begin
        rst = 1'b1; bus_en = 0; bus_we = 0; bus_addr = 0; bus_wdata = 0;
        #2;
        tag = "R1"; cyc(1, 0, 0, 2'd0, '0); cyc(1, 0, 0, 2'd0, '0); idle(3);
        tag = "R8"; idle(4);                       // period 0 after reset: no motion
        tag = "R2"; wr(2'd2, {8'd4, 24'd10}); idle(25);
        tag = "R10"; rd(2'd2); idle(2); wr(2'd3, 32'hDEAD_BEEF); rd(2'd3); rd(2'd2); idle(1);
        tag = "R9"; idle(1); wr(2'd2, {8'd2, 24'd100}); idle(12);
        tag = "R7"; wr(2'd0, 32'h1234_5678); idle(5); wr(2'd1, 32'h0000_00AB); idle(7);
        tag = "R6"; rd(2'd0); idle(9); rd(2'd1); idle(2);
        tag = "R8"; wr(2'd2, 32'h0000_0055); idle(12);
        tag = "R3"; wr(2'd2, 32'h03FA_0000); idle(20);
        tag = "R4"; wr(2'd2, 32'h01A0_0000); idle(10);
        tag = "R5"; wr(2'd0, 32'hFFFF_FFF0); wr(2'd1, 32'hFFFF_FFFF); idle(4);
        rd(2'd0); rd(2'd1); idle(1);
        tag = "R7"; wr(2'd2, {8'd5, 24'd7}); idle(6); wr(2'd0, 32'h0); wr(2'd1, 32'h0); idle(12);
        tag = "R11"; rd(2'd0); cyc(1, 0, 0, 2'd0, '0); idle(6); rd(2'd1); idle(1);
        tag = "R11"; wr(2'd2, {8'd1, 24'd3}); idle(6);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule